// File: doc/BRIEF.md
# Video Field Timing Generator

This block is the horizontal and vertical time base of a digital video encoder. It counts sample positions along a line, lines within a field, and fields within an eight-field cycle. All three advance on a sample-rate clock enable. Line length, field length, the active line range, and the horizontal pulse window are all set by configuration inputs. An active-region flag marks the lines that carry picture content. The active region always starts at the first sample of a line.

In master mode the time base runs freely and drives two sync ports. The vertical port carries one of five selectable formats. The horizontal port carries a pulse with programmed start and stop positions, and that pulse can be blanked outside the active lines to form a composite blanking signal.

In slave mode the output enable of each port used as an input is dropped. The counters then lock to edges arriving on those ports. A vertical edge reloads the line counter after a programmable delay. The same edge can optionally also reload the field phase and the sample position. A horizontal edge on the second port realigns the sample position. When edges are absent, the counters keep running on their programmed lengths.

Top module: `vtg_field_timer`

## Requirements
- R1: On each tick, `pix_cnt` counts 0 to `line_len`-1 and wraps. At a wrap, `line_cnt` advances, and it wraps from `field_len`-1 to 0. At that line wrap, `field_cnt` (3 bits) increments. Reset clears all three counters.
- R2: `active` is high exactly when `act_first` <= `line_cnt` <= `act_last`.
- R3: With `vfmt`=0, the raw vertical signal is high on lines 0, 1 and 2 of every field.
- R4: With `vfmt`=1, the raw vertical signal spans 2.5 lines, with half = `line_len`>>1. In odd fields (`field_cnt` bit 0 = 0) it is high on lines 0 and 1, and on line 2 while `pix_cnt` < half. In even fields it is high on line 0 while `pix_cnt` >= half, and on lines 1 and 2.
- R5: The raw vertical signal follows the other format codes:
  - `vfmt`=2: it equals `field_cnt` bit 0, so it is low in odd fields.
  - `vfmt`=3: it is high when `field_cnt`[1:0]=0.
  - `vfmt`=4: it is high when `field_cnt`=0.
- R6: The raw horizontal signal is high when `hs_start` <= `pix_cnt` < `hs_stop`. When `hs_blank_en`=1 it is forced low while `active`=0.
- R7: `p1_out` = raw vertical XOR `p1_pol`, and `p2_out` = raw horizontal XOR `p2_pol`.
- R8: In master mode both output enables are 1. In slave mode `p1_oe`=0 and `p2_oe`=`slv_h_from_p1`.
- R9: In slave mode the first port is normalised as `p1_in` XOR `p1_pol`, and it is sampled on ticks. A rising edge of that normalised level, seen at tick T, causes a reload at tick T+1+`slv_delay`:
  - `line_cnt` is reloaded from `preset_line`.
  - If `slv_set_parity`=1, `field_cnt` is cleared.
  - If `slv_h_from_p1`=1, `pix_cnt` is loaded from `preset_pix`.
  - Edges seen while a reload is pending are ignored.
- R10: In slave mode with `slv_h_from_p1`=0, a rising edge of `p2_in` XOR `p2_pol` seen at a tick loads `pix_cnt` from `preset_pix` at the next tick. A line advance due at that tick still happens. When `slv_h_from_p1`=1, `p2_in` has no effect.
- R11: In slave mode without edges, the counters run exactly as in R1.
- R12: In master mode `p1_in` and `p2_in` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample-rate clock enable |
| master | input | 1 | 1 = free-running master, 0 = slave |
| line_len | input | PIX_W | Ticks per line |
| field_len | input | LINE_W | Lines per field |
| act_first | input | LINE_W | First active line |
| act_last | input | LINE_W | Last active line |
| preset_pix | input | PIX_W | Sample position loaded on a horizontal reload |
| preset_line | input | LINE_W | Line loaded on a vertical reload |
| vfmt | input | 3 | Vertical port format code |
| hs_start | input | PIX_W | Horizontal pulse first position |
| hs_stop | input | PIX_W | Horizontal pulse end position (exclusive) |
| hs_blank_en | input | 1 | Blank horizontal pulse outside active lines |
| p1_pol | input | 1 | First port polarity invert |
| p2_pol | input | 1 | Second port polarity invert |
| slv_delay | input | DLY_W | Ticks of delay applied to a vertical edge |
| slv_h_from_p1 | input | 1 | Vertical edge also sets horizontal phase |
| slv_set_parity | input | 1 | Vertical edge also clears field phase |
| p1_in | input | 1 | First sync pin, input side |
| p2_in | input | 1 | Second sync pin, input side |
| p1_out | output | 1 | First sync pin, output side |
| p1_oe | output | 1 | First sync pin output enable |
| p2_out | output | 1 | Second sync pin, output side |
| p2_oe | output | 1 | Second sync pin output enable |
| pix_cnt | output | PIX_W | Sample position in line |
| line_cnt | output | LINE_W | Line in field |
| field_cnt | output | 3 | Field in eight-field cycle |
| active | output | 1 | Active-region flag |

## Verification
The bench targets the half-line split of the 2.5-line format at odd and even line lengths. A design that computed the half point wrongly, or swapped the field halves, would put the vertical edge in the wrong place. It also checks the exact tick at which a delayed vertical edge takes effect. An off-by-one delay counter would reload one tick early or late. Edges that land while a reload is still pending are exercised, and so are horizontal edges that coincide with a line wrap. A design that let the horizontal reload swallow the line advance would drop a line. Long gaps without edges confirm that the slave keeps free-running. Random pin activity in master mode checks that both inputs are ignored.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int FSEQ_W = 3;

    typedef enum logic [2:0] {
        VF_VS3    = 3'd0,
        VF_VS25   = 3'd1,
        VF_PARITY = 3'd2,
        VF_SEQ4   = 3'd3,
        VF_SEQ8   = 3'd4
    } vport_fmt_e;

    typedef struct packed {
        logic v;   // vertical reload this tick
        logic h;   // sample position reload this tick
    } load_req_t;

    // 2.5-line vertical window; lsel: 0..2 = line 0..2, 3 = any other line
    function automatic logic vs25_on(input logic odd, input logic [1:0] lsel,
                                     input logic first_half);
        logic r;
        if (odd)
            r = (lsel == 2'd0) || (lsel == 2'd1) || ((lsel == 2'd2) && first_half);
        else
            r = ((lsel == 2'd0) && !first_half) || (lsel == 2'd1) || (lsel == 2'd2);
        return r;
    endfunction

endpackage

// File: rtl/vtg_slave_lock.sv
module vtg_slave_lock
    import vtg_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             master,
    input  logic             h_from_p1,
    input  logic             lvl1,
    input  logic             lvl2,
    input  logic [DLY_W-1:0] delay,
    output load_req_t        req
);

    logic             prev1, prev2, pend, hpend;
    logic [DLY_W-1:0] cnt;
    logic             e1, e2, fire_v;

    assign e1     = lvl1 & ~prev1 & ~master;
    assign e2     = lvl2 & ~prev2 & ~master & ~h_from_p1;
    assign fire_v = tick & pend & (cnt == '0) & ~master;
    assign req.v  = fire_v;
    assign req.h  = tick & ~master & ((fire_v & h_from_p1) | hpend);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev1 <= 1'b1;
            prev2 <= 1'b1;
            pend  <= 1'b0;
            hpend <= 1'b0;
            cnt   <= '0;
        end else if (tick) begin
            prev1 <= lvl1;
            prev2 <= lvl2;
            hpend <= e2;
            if (master) begin
                pend <= 1'b0;
            end else if (pend) begin
                if (cnt == '0) pend <= 1'b0;
                else           cnt  <= cnt - DLY_W'(1);
            end else if (e1) begin
                pend <= 1'b1;
                cnt  <= delay;
            end
        end
    end

    AST_SINGLE_RELOAD: assert property (@(posedge clk) disable iff (rst)
        req.v |=> !req.v); // R9

endmodule

// File: rtl/vtg_counters.sv
module vtg_counters
    import vtg_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [PIX_W-1:0]  line_len,
    input  logic [LINE_W-1:0] field_len,
    input  logic [PIX_W-1:0]  preset_pix,
    input  logic [LINE_W-1:0] preset_line,
    input  logic              set_parity,
    input  logic              master,
    input  load_req_t         req,
    output logic [PIX_W-1:0]  pix,
    output logic [LINE_W-1:0] line,
    output logic [FSEQ_W-1:0] fseq
);

    logic pix_last, line_last;

    assign pix_last  = (pix == line_len - PIX_W'(1));
    assign line_last = (line == field_len - LINE_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pix  <= '0;
            line <= '0;
            fseq <= '0;
        end else if (tick) begin
            if (req.h)         pix <= preset_pix;
            else if (pix_last) pix <= '0;
            else               pix <= pix + PIX_W'(1);

            if (req.v) begin
                line <= preset_line;
                if (set_parity) fseq <= '0;
            end else if (pix_last) begin
                if (line_last) begin
                    line <= '0;
                    fseq <= fseq + FSEQ_W'(1);
                end else begin
                    line <= line + LINE_W'(1);
                end
            end
        end
    end

    AST_PIX_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && !req.h && pix_last) |=> (pix == '0)); // R1
    AST_FIELD_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !req.v && pix_last && line_last) |=> (fseq == $past(fseq) + 3'd1)); // R1
    AST_LINE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && req.v) |=> (line == $past(preset_line))); // R9
    AST_PIX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && req.h) |=> (pix == $past(preset_pix))); // R10
    AST_MASTER_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        master |-> !(req.v || req.h)); // R12

endmodule

// File: rtl/vtg_port_fmt.sv
module vtg_port_fmt
    import vtg_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 10
) (
    input  logic [PIX_W-1:0]  pix,
    input  logic [LINE_W-1:0] line,
    input  logic [FSEQ_W-1:0] fseq,
    input  logic [PIX_W-1:0]  line_len,
    input  logic [LINE_W-1:0] act_first,
    input  logic [LINE_W-1:0] act_last,
    input  logic [2:0]        vfmt,
    input  logic [PIX_W-1:0]  hs_start,
    input  logic [PIX_W-1:0]  hs_stop,
    input  logic              hs_blank_en,
    output logic              v_raw,
    output logic              h_raw,
    output logic              active
);

    vport_fmt_e       fmt;
    logic [PIX_W-1:0] half;
    logic [1:0]       lsel;

    assign fmt    = vport_fmt_e'(vfmt);
    assign half   = line_len >> 1;
    assign lsel   = (line < LINE_W'(3)) ? line[1:0] : 2'd3;
    assign active = (line >= act_first) && (line <= act_last);

    always_comb begin
        case (fmt)
            VF_VS3:    v_raw = (lsel != 2'd3);
            VF_VS25:   v_raw = vs25_on(!fseq[0], lsel, pix < half);
            VF_PARITY: v_raw = fseq[0];
            VF_SEQ4:   v_raw = (fseq[1:0] == 2'd0);
            VF_SEQ8:   v_raw = (fseq == '0);
            default:   v_raw = 1'b0;
        endcase
    end

    assign h_raw = (pix >= hs_start) && (pix < hs_stop) && !(hs_blank_en && !active);

endmodule

// File: rtl/vtg_field_timer.sv
module vtg_field_timer
    import vtg_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 10,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              master,
    input  logic [PIX_W-1:0]  line_len,
    input  logic [LINE_W-1:0] field_len,
    input  logic [LINE_W-1:0] act_first,
    input  logic [LINE_W-1:0] act_last,
    input  logic [PIX_W-1:0]  preset_pix,
    input  logic [LINE_W-1:0] preset_line,
    input  logic [2:0]        vfmt,
    input  logic [PIX_W-1:0]  hs_start,
    input  logic [PIX_W-1:0]  hs_stop,
    input  logic              hs_blank_en,
    input  logic              p1_pol,
    input  logic              p2_pol,
    input  logic [DLY_W-1:0]  slv_delay,
    input  logic              slv_h_from_p1,
    input  logic              slv_set_parity,
    input  logic              p1_in,
    input  logic              p2_in,
    output logic              p1_out,
    output logic              p1_oe,
    output logic              p2_out,
    output logic              p2_oe,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [LINE_W-1:0] line_cnt,
    output logic [2:0]        field_cnt,
    output logic              active
);

    load_req_t req;
    logic      v_raw, h_raw;

    vtg_slave_lock #(.DLY_W(DLY_W)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .master    (master),
        .h_from_p1 (slv_h_from_p1),
        .lvl1      (p1_in ^ p1_pol),
        .lvl2      (p2_in ^ p2_pol),
        .delay     (slv_delay),
        .req       (req)
    );

    vtg_counters #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .line_len    (line_len),
        .field_len   (field_len),
        .preset_pix  (preset_pix),
        .preset_line (preset_line),
        .set_parity  (slv_set_parity),
        .master      (master),
        .req         (req),
        .pix         (pix_cnt),
        .line        (line_cnt),
        .fseq        (field_cnt)
    );

    vtg_port_fmt #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_fmt (
        .pix         (pix_cnt),
        .line        (line_cnt),
        .fseq        (field_cnt),
        .line_len    (line_len),
        .act_first   (act_first),
        .act_last    (act_last),
        .vfmt        (vfmt),
        .hs_start    (hs_start),
        .hs_stop     (hs_stop),
        .hs_blank_en (hs_blank_en),
        .v_raw       (v_raw),
        .h_raw       (h_raw),
        .active      (active)
    );

    assign p1_out = v_raw ^ p1_pol;
    assign p2_out = h_raw ^ p2_pol;
    assign p1_oe  = master;
    assign p2_oe  = master | slv_h_from_p1;

endmodule

// File: tb/vtg_field_timer_tb.sv
module vtg_field_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        master = 1'b1;
    logic [11:0] line_len = 12'd16;
    logic [9:0]  field_len = 10'd8;
    logic [9:0]  act_first = 10'd3;
    logic [9:0]  act_last = 10'd6;
    logic [11:0] preset_pix = 12'd5;
    logic [9:0]  preset_line = 10'd2;
    logic [2:0]  vfmt = 3'd0;
    logic [11:0] hs_start = 12'd2;
    logic [11:0] hs_stop = 12'd6;
    logic        hs_blank_en = 1'b0;
    logic        p1_pol = 1'b0, p2_pol = 1'b0;
    logic [7:0]  slv_delay = 8'd0;
    logic        slv_h_from_p1 = 1'b0, slv_set_parity = 1'b0;
    logic        p1_in = 1'b0, p2_in = 1'b0;
    logic        p1_out, p1_oe, p2_out, p2_oe, active;
    logic [11:0] pix_cnt;
    logic [9:0]  line_cnt;
    logic [2:0]  field_cnt;

    int n_chk = 0, n_fail = 0;
    bit check_en = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vtg_field_timer u_dut (
        .clk(clk), .rst(rst), .tick(tick), .master(master),
        .line_len(line_len), .field_len(field_len),
        .act_first(act_first), .act_last(act_last),
        .preset_pix(preset_pix), .preset_line(preset_line), .vfmt(vfmt),
        .hs_start(hs_start), .hs_stop(hs_stop), .hs_blank_en(hs_blank_en),
        .p1_pol(p1_pol), .p2_pol(p2_pol), .slv_delay(slv_delay),
        .slv_h_from_p1(slv_h_from_p1), .slv_set_parity(slv_set_parity),
        .p1_in(p1_in), .p2_in(p2_in),
        .p1_out(p1_out), .p1_oe(p1_oe), .p2_out(p2_out), .p2_oe(p2_oe),
        .pix_cnt(pix_cnt), .line_cnt(line_cnt), .field_cnt(field_cnt),
        .active(active)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- expected-value model ----------------
    logic [11:0] m_pix;
    logic [9:0]  m_line;
    logic [2:0]  m_fs;
    logic        m_prev1, m_prev2, m_pend, m_hpend;
    logic [7:0]  m_cnt;

    function automatic logic exp_active(input logic [9:0] ln);
        return (ln >= act_first) && (ln <= act_last);
    endfunction

    function automatic logic exp_vraw(input logic [11:0] px, input logic [9:0] ln,
                                      input logic [2:0] fs);
        logic [11:0] half;
        logic        fh;
        half = line_len >> 1;
        fh   = px < half;
        case (vfmt)
            3'd0: return ln < 10'd3;
            3'd1: if (!fs[0]) return (ln < 10'd2) || (ln == 10'd2 && fh);
                  else        return (ln == 10'd0 && !fh) || ln == 10'd1 || ln == 10'd2;
            3'd2: return fs[0];
            3'd3: return fs[1:0] == 2'd0;
            3'd4: return fs == 3'd0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_hraw(input logic [11:0] px, input logic [9:0] ln);
        return (px >= hs_start) && (px < hs_stop) && !(hs_blank_en && !exp_active(ln));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pix = 0; m_line = 0; m_fs = 0;
            m_prev1 = 1; m_prev2 = 1; m_pend = 0; m_hpend = 0; m_cnt = 0;
        end else if (tick) begin
            logic l1, l2, e1, e2, rv, rh, plast;
            l1 = p1_in ^ p1_pol;
            l2 = p2_in ^ p2_pol;
            e1 = l1 && !m_prev1 && !master;
            e2 = l2 && !m_prev2 && !master && !slv_h_from_p1;
            rv = m_pend && (m_cnt == 0) && !master;
            rh = !master && ((rv && slv_h_from_p1) || m_hpend);
            plast = (m_pix == line_len - 12'd1);
            if (rv) begin
                m_line = preset_line;
                if (slv_set_parity) m_fs = 0;
            end else if (plast) begin
                if (m_line == field_len - 10'd1) begin m_line = 0; m_fs = m_fs + 3'd1; end
                else m_line = m_line + 10'd1;
            end
            if (rh) m_pix = preset_pix;
            else if (plast) m_pix = 0;
            else m_pix = m_pix + 12'd1;
            if (master) m_pend = 0;
            else if (m_pend) begin
                if (m_cnt == 0) m_pend = 0; else m_cnt = m_cnt - 8'd1;
            end else if (e1) begin m_pend = 1; m_cnt = slv_delay; end
            m_hpend = e2;
            m_prev1 = l1;
            m_prev2 = l2;
        end
    end

    string ctag = "R1";
    string vtag = "R3";

    always @(negedge clk) begin
        if (check_en && !rst) begin
            chk(pix_cnt == m_pix && line_cnt == m_line && field_cnt == m_fs,
                {ctag, " counters"}, {pix_cnt, line_cnt, field_cnt}, {m_pix, m_line, m_fs});
            chk(active == exp_active(m_line), "R2 active", active, exp_active(m_line));
            chk(p1_out == (exp_vraw(m_pix, m_line, m_fs) ^ p1_pol), {vtag, " R7 p1_out"},
                p1_out, exp_vraw(m_pix, m_line, m_fs) ^ p1_pol);
            chk(p2_out == (exp_hraw(m_pix, m_line) ^ p2_pol), "R6 R7 p2_out",
                p2_out, exp_hraw(m_pix, m_line) ^ p2_pol);
            chk(p1_oe == master && p2_oe == (master | slv_h_from_p1), "R8 oe",
                {p1_oe, p2_oe}, {master, master | slv_h_from_p1});
        end
    end

    // ---------------- stimulus ----------------
    task automatic restart();
        check_en = 0;
        @(posedge clk); #1 rst = 1; tick = 0; p1_in = p1_pol; p2_in = p2_pol;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(pix_cnt == 0 && line_cnt == 0 && field_cnt == 0, "R1 reset",
            pix_cnt + line_cnt + field_cnt, 0);
        @(posedge clk); #1 rst = 0;
        check_en = 1;
    endtask

    // kind: 0 master random pins, 1 slave p1 pulses + random p2, 2 slave p2 pulses
    task automatic run(input int n, input int kind);
        int h1 = 0, h2 = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            tick = ($urandom % 4) != 0;
            if (kind == 0) begin
                p1_in = $urandom % 2;
                p2_in = $urandom % 2;
            end else begin
                if (h1 > 0) h1--; else if (kind == 1 && ($urandom % 150) == 0) h1 = 4;
                if (h2 > 0) h2--; else if (kind == 2 && ($urandom % 25) == 0) h2 = 2;
                p1_in = (h1 > 0) ^ p1_pol;
                p2_in = (kind == 1) ? 1'($urandom % 2) : ((h2 > 0) ^ p2_pol);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // master, 3-line VS (R3), random pins ignored (R12)
        master = 1; vfmt = 3'd0; ctag = "R1 R12"; vtag = "R3";
        restart(); run(1600, 0);
        // 2.5-line VS, odd line length, inverted ports, blanking (R4)
        vfmt = 3'd1; vtag = "R4"; line_len = 12'd21; p1_pol = 1; p2_pol = 1; hs_blank_en = 1;
        restart(); run(1600, 0);
        line_len = 12'd16;
        restart(); run(1000, 0);
        // parity and sequence formats (R5)
        vtag = "R5"; p1_pol = 0; p2_pol = 0; hs_blank_en = 0;
        vfmt = 3'd2; restart(); run(1200, 0);
        vfmt = 3'd3; restart(); run(1600, 0);
        vfmt = 3'd4; restart(); run(1800, 0);
        // slave, vertical edge sets all phases, delayed (R9, R10 ignore, R11)
        master = 0; vfmt = 3'd0; vtag = "R3"; ctag = "R9 R10 R11";
        slv_h_from_p1 = 1; slv_set_parity = 1; slv_delay = 8'd3; p1_pol = 1;
        restart(); run(3000, 1);
        // slave, horizontal from second port, field phase kept (R10)
        slv_h_from_p1 = 0; slv_set_parity = 0; slv_delay = 8'd0; p1_pol = 0; p2_pol = 1;
        ctag = "R10 R11";
        restart(); run(3000, 2);
        // directed: delay 2, continuous tick, edge timing (R9)
        slv_h_from_p1 = 1; slv_set_parity = 1; slv_delay = 8'd2; ctag = "R9";
        restart();
        @(posedge clk); #1 tick = 1; p1_in = 0;
        repeat (40) @(posedge clk);
        #1 p1_in = 1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(line_cnt == preset_line && pix_cnt == preset_pix && field_cnt == 0,
            "R9 directed reload", line_cnt, preset_line);
        repeat (10) @(posedge clk);
        check_en = 0;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule